// File: doc/BRIEF.md
# Shadowed Ramp Reference Generator

This block supplies the digital code for a comparator's reference DAC. The code comes from one of two places. Software can write a 12-bit value into a shadow register and have it taken up either at once or only at the next period sync. The other source is a 16-bit down-counting ramp. On every period sync the ramp is reloaded from a peak value. It then waits a programmed number of clocks and falls by a programmed step each clock until it reaches zero or a comparator trip freezes it.

Every ramp parameter has a shadow copy that software writes and an active copy that the ramp uses. The active copies take the shadow values on each sync, so software can change the ramp mid-period without tearing the current ramp. A two-bit suspend mode sets how the ramp behaves while a debug halt input is high.

Top module: `ramp_ref_gen`

## Requirements
- R1: A write (`wr_en`=1) lands in the register named by `wr_addr` at the next clock edge. Code 1 takes `wr_data[11:0]` as the DAC shadow. Code 2 takes the 16-bit peak shadow and code 3 the 16-bit step shadow. Code 4 takes `wr_data[12:0]` as the delay shadow. Code 0 is the control word: bit 0 ramp source, bit 1 sync-only load, bit 2 reload from peak shadow, bits 4:3 suspend mode. Codes 5 to 7 are ignored.
- R2: With control bits 0 and 1 both 0, `dac_o` equals the DAC shadow as it stood one clock earlier.
- R3: With bit 0 = 0 and bit 1 = 1, `dac_o` holds its value and takes the DAC shadow only at a clock edge where `sync_i` is high.
- R4: With bit 0 = 1, `dac_o` equals bits 15:4 of `ramp_o` as it stood one clock earlier.
- R5: At each sync edge the ramp reloads. With bit 2 = 1 it reloads from the peak shadow. With bit 2 = 0 it reloads from the active peak, which is the shadow value captured at the previous sync. At the same edge the shadow peak, step and delay are copied into their active copies.
- R6: With active delay D, `ramp_o` holds the reloaded value for D clock edges after the sync edge. The first step is applied at edge D+1.
- R7: After the delay, `ramp_o` falls by the active step at every clock edge. It stops at 0 instead of wrapping, and it never rises except on a reload.
- R8: A clock edge with `trip_i` high applies no step. From then on `ramp_o` holds until the next sync reload, and stepping resumes after that reload.
- R9: Suspend mode 00: while `susp_i` is high, the ramp, its delay count and its sync reload are frozen.
- R10: Suspend mode 01: while `susp_i` is high the ramp keeps running. The first sync edge in that state does not reload, and the ramp then stays frozen until `susp_i` falls. After that it continues from the held value.
- R11: Suspend modes 10 and 11: `susp_i` has no effect on the ramp.
- R12: Reset clears every register, so `dac_o` and `ramp_o` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register code of the write |
| wr_data | input | 16 | Write data |
| sync_i | input | 1 | One-clock period sync pulse |
| trip_i | input | 1 | Comparator trip, halts the ramp until sync |
| susp_i | input | 1 | Debug suspend request |
| dac_o | output | 12 | Active DAC code |
| ramp_o | output | 16 | Present ramp value |

## Verification
An active copy captured at the wrong sync shows up as a reload to the wrong peak, or as a wrong step, in the period after that sync. It is visible on `ramp_o` within one period. A delay counter that is off by one moves the first step by one clock, which is seen on the edge numbered D+1. A trip or suspend flag that is lost or sticks shows as a ramp that moves when it should hold, or holds when it should move. This appears on the next clock. The ramp-to-DAC path lags `ramp_o` by exactly one register, so a wrong slice or a missing stage is visible on `dac_o` one clock after any ramp step.

// File: rtl/ramp_ref_pkg.sv
package ramp_ref_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RC_CTRL  = 3'd0,
    RC_DAC   = 3'd1,
    RC_PEAK  = 3'd2,
    RC_STEP  = 3'd3,
    RC_DELAY = 3'd4
  } reg_code_e;

  typedef enum logic [1:0] {
    SM_HALT   = 2'b00,
    SM_FINISH = 2'b01,
    SM_FREE0  = 2'b10,
    SM_FREE1  = 2'b11
  } susp_mode_e;

  typedef struct packed {
    susp_mode_e susp;
    logic       peak_from_shadow;
    logic       load_on_sync;
    logic       src_ramp;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/rr_regs.sv
module rr_regs
  import ramp_ref_pkg::*;
#(
  parameter int DAC_W  = 12,
  parameter int RAMP_W = 16,
  parameter int DLY_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [RAMP_W-1:0] wr_data,
  input  logic              sync_i,
  output ctrl_t             ctrl_q,
  output logic [DAC_W-1:0]  dac_sh_q,
  output logic [RAMP_W-1:0] peak_sh_q,
  output logic [RAMP_W-1:0] peak_act_q,
  output logic [RAMP_W-1:0] step_act_q,
  output logic [DLY_W-1:0]  dly_act_q
);

  logic [RAMP_W-1:0] step_sh_q;
  logic [DLY_W-1:0]  dly_sh_q;

  // shadow registers, written by software
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      dac_sh_q  <= '0;
      peak_sh_q <= '0;
      step_sh_q <= '0;
      dly_sh_q  <= '0;
    end else if (wr_en) begin
      case (reg_code_e'(wr_addr))
        RC_CTRL:  ctrl_q    <= ctrl_t'(wr_data[CTRL_W-1:0]);
        RC_DAC:   dac_sh_q  <= wr_data[DAC_W-1:0];
        RC_PEAK:  peak_sh_q <= wr_data;
        RC_STEP:  step_sh_q <= wr_data;
        RC_DELAY: dly_sh_q  <= wr_data[DLY_W-1:0];
        default:  ;
      endcase
    end
  end

  // active copies, refreshed at each period sync
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      peak_act_q <= '0;
      step_act_q <= '0;
      dly_act_q  <= '0;
    end else if (sync_i) begin
      peak_act_q <= peak_sh_q;
      step_act_q <= step_sh_q;
      dly_act_q  <= dly_sh_q;
    end
  end

endmodule

// File: rtl/rr_ramp.sv
module rr_ramp
  import ramp_ref_pkg::*;
#(
  parameter int RAMP_W = 16,
  parameter int DLY_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_i,
  input  logic              trip_i,
  input  logic              susp_i,
  input  susp_mode_e        susp_mode,
  input  logic [RAMP_W-1:0] reload_val,
  input  logic [RAMP_W-1:0] step_act,
  input  logic [DLY_W-1:0]  dly_act,
  output logic [RAMP_W-1:0] ramp_q,
  output logic              reload_ev,
  output logic              wait_ev,
  output logic              freeze,
  output logic              hold_q
);

  localparam logic [DLY_W-1:0] DLY_ONE = DLY_W'(1);

  logic [DLY_W-1:0] elapsed_q;
  logic             stop_q;
  logic             stop_req;
  logic             finish_mode;

  function automatic logic [RAMP_W-1:0] sat_sub(input logic [RAMP_W-1:0] a,
                                                input logic [RAMP_W-1:0] b);
    return (a < b) ? '0 : a - b;
  endfunction

  assign finish_mode = (susp_mode == SM_FINISH);
  assign freeze      = susp_i && ((susp_mode == SM_HALT) || (finish_mode && stop_q));
  assign stop_req    = sync_i && susp_i && finish_mode && !stop_q;
  assign reload_ev   = sync_i && !freeze && !stop_req;
  assign wait_ev     = (elapsed_q < dly_act);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ramp_q    <= '0;
      elapsed_q <= '0;
      hold_q    <= 1'b0;
    end else if (reload_ev) begin
      ramp_q    <= reload_val;
      elapsed_q <= '0;
      hold_q    <= 1'b0;
    end else if (!freeze && !stop_req) begin
      if (trip_i) hold_q <= 1'b1;
      if (wait_ev) elapsed_q <= elapsed_q + DLY_ONE;
      else if (!hold_q && !trip_i) ramp_q <= sat_sub(ramp_q, step_act);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stop_q <= 1'b0;
    else if (!susp_i || !finish_mode) stop_q <= 1'b0;
    else if (stop_req) stop_q <= 1'b1;
  end

endmodule

// File: rtl/rr_dac_sel.sv
module rr_dac_sel #(
  parameter int DAC_W  = 12,
  parameter int RAMP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_i,
  input  logic              src_ramp,
  input  logic              load_on_sync,
  input  logic [DAC_W-1:0]  dac_sh,
  input  logic [RAMP_W-1:0] ramp,
  output logic [DAC_W-1:0]  dac_q
);

  function automatic logic [DAC_W-1:0] ramp_to_code(input logic [RAMP_W-1:0] r);
    return r[RAMP_W-1 -: DAC_W];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) dac_q <= '0;
    else if (src_ramp) dac_q <= ramp_to_code(ramp);
    else if (!load_on_sync || sync_i) dac_q <= dac_sh;
  end

endmodule

// File: rtl/ramp_ref_gen.sv
module ramp_ref_gen
  import ramp_ref_pkg::*;
#(
  parameter int DAC_W  = 12,
  parameter int RAMP_W = 16,
  parameter int DLY_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [RAMP_W-1:0] wr_data,
  input  logic              sync_i,
  input  logic              trip_i,
  input  logic              susp_i,
  output logic [DAC_W-1:0]  dac_o,
  output logic [RAMP_W-1:0] ramp_o
);

  ctrl_t             ctrl;
  logic [DAC_W-1:0]  dac_shadow;
  logic [RAMP_W-1:0] peak_sh, peak_act, step_act, reload_val;
  logic [DLY_W-1:0]  dly_act;
  logic              reload_ev, wait_ev, freeze, hold_q;

  rr_regs #(.DAC_W(DAC_W), .RAMP_W(RAMP_W), .DLY_W(DLY_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sync_i(sync_i), .ctrl_q(ctrl),
    .dac_sh_q(dac_shadow), .peak_sh_q(peak_sh), .peak_act_q(peak_act),
    .step_act_q(step_act), .dly_act_q(dly_act)
  );

  assign reload_val = ctrl.peak_from_shadow ? peak_sh : peak_act;

  rr_ramp #(.RAMP_W(RAMP_W), .DLY_W(DLY_W)) u_ramp (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .trip_i(trip_i),
    .susp_i(susp_i), .susp_mode(ctrl.susp), .reload_val(reload_val),
    .step_act(step_act), .dly_act(dly_act), .ramp_q(ramp_o),
    .reload_ev(reload_ev), .wait_ev(wait_ev), .freeze(freeze), .hold_q(hold_q)
  );

  rr_dac_sel #(.DAC_W(DAC_W), .RAMP_W(RAMP_W)) u_dac (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .src_ramp(ctrl.src_ramp),
    .load_on_sync(ctrl.load_on_sync), .dac_sh(dac_shadow), .ramp(ramp_o),
    .dac_q(dac_o)
  );

endmodule

// File: rtl/ramp_ref_gen_chk.sv
module ramp_ref_gen_chk #(
  parameter int DAC_W  = 12,
  parameter int RAMP_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sync_i,
  input logic              src_ramp,
  input logic              load_on_sync,
  input logic [DAC_W-1:0]  dac_shadow,
  input logic [RAMP_W-1:0] ramp_o,
  input logic [DAC_W-1:0]  dac_o,
  input logic              reload_ev,
  input logic              wait_ev,
  input logic              freeze,
  input logic              hold_q
);

  assert_dac_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_ramp && !load_on_sync) |=> (dac_o == $past(dac_shadow)));

  assert_dac_sync_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_ramp && load_on_sync && !sync_i) |=> $stable(dac_o));

  assert_dac_from_ramp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    src_ramp |=> (dac_o == $past(ramp_o[RAMP_W-1 -: DAC_W])));

  assert_wait_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_ev && !reload_ev) |=> $stable(ramp_o));

  assert_no_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !reload_ev |=> (ramp_o <= $past(ramp_o)));

  assert_trip_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !reload_ev) |=> $stable(ramp_o));

  assert_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> $stable(ramp_o));

endmodule

bind ramp_ref_gen ramp_ref_gen_chk #(.DAC_W(DAC_W), .RAMP_W(RAMP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .src_ramp(ctrl.src_ramp),
  .load_on_sync(ctrl.load_on_sync), .dac_shadow(dac_shadow), .ramp_o(ramp_o),
  .dac_o(dac_o), .reload_ev(reload_ev), .wait_ev(wait_ev), .freeze(freeze),
  .hold_q(hold_q)
);

// File: tb/ramp_ref_gen_test.sv
module ramp_ref_gen_test;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        sync_i = 1'b0, trip_i = 1'b0, susp_i = 1'b0;
  logic [11:0] dac_o;
  logic [15:0] ramp_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  ramp_ref_gen uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sync_i(sync_i), .trip_i(trip_i), .susp_i(susp_i),
    .dac_o(dac_o), .ramp_o(ramp_o)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic pulse_sync();
    sync_i = 1'b1;
    tick();
    sync_i = 1'b0;
  endtask

  // R12
  task automatic t_reset();
    check("R12 dac after reset", {4'h0, dac_o}, 16'h0000);
    check("R12 ramp after reset", ramp_o, 16'h0000);
  endtask

  // R1 R2: immediate shadow load, upper bits dropped
  task automatic t_shadow_now();
    wr(3'd1, 16'hFABC);
    check("R2 dac one clock after write", {4'h0, dac_o}, 16'h0000);
    tick();
    check("R1 R2 dac follows shadow", {4'h0, dac_o}, 16'h0ABC);
    wr(3'd6, 16'h0123);
    tick();
    check("R1 unmapped code ignored", {4'h0, dac_o}, 16'h0ABC);
  endtask

  // R3: sync-only DAC load
  task automatic t_shadow_sync();
    wr(3'd0, 16'h0002);
    wr(3'd1, 16'h0123);
    tick(); tick();
    check("R3 dac held without sync", {4'h0, dac_o}, 16'h0ABC);
    pulse_sync();
    check("R3 dac loaded on sync", {4'h0, dac_o}, 16'h0123);
  endtask

  // R4 R5 R6 R7: ramp from shadow peak with delay 3
  task automatic t_ramp_delay();
    wr(3'd0, 16'h0005);
    wr(3'd2, 16'h8000);
    wr(3'd3, 16'h0100);
    wr(3'd4, 16'h0003);
    pulse_sync();
    check("R5 reload from shadow peak", ramp_o, 16'h8000);
    tick(); tick(); tick();
    check("R6 held through delay", ramp_o, 16'h8000);
    tick();
    check("R6 R7 first step at D+1", ramp_o, 16'h7F00);
    tick();
    check("R7 second step", ramp_o, 16'h7E00);
    check("R4 dac is lagged ramp slice", {4'h0, dac_o}, 16'h07F0);
  endtask

  // R7: saturation at zero
  task automatic t_saturate();
    wr(3'd3, 16'h7000);
    pulse_sync();
    tick(); tick(); tick(); tick();
    check("R7 large step", ramp_o, 16'h1000);
    tick();
    check("R7 saturates at zero", ramp_o, 16'h0000);
    tick();
    check("R7 stays at zero", ramp_o, 16'h0000);
  endtask

  // R5: reload from active peak lags one sync
  task automatic t_active_peak();
    wr(3'd0, 16'h0001);
    wr(3'd2, 16'h4000);
    pulse_sync();
    check("R5 reload from old active peak", ramp_o, 16'h8000);
    pulse_sync();
    check("R5 active peak updated at sync", ramp_o, 16'h4000);
  endtask

  // R8: trip holds until sync
  task automatic t_trip();
    wr(3'd0, 16'h0005);
    wr(3'd2, 16'h1000);
    wr(3'd3, 16'h0010);
    wr(3'd4, 16'h0000);
    pulse_sync();
    tick(); tick();
    check("R8 running before trip", ramp_o, 16'h0FE0);
    trip_i = 1'b1;
    tick();
    trip_i = 1'b0;
    check("R8 no step on trip edge", ramp_o, 16'h0FE0);
    tick(); tick();
    check("R8 held after trip", ramp_o, 16'h0FE0);
    pulse_sync();
    check("R8 sync reloads", ramp_o, 16'h1000);
    tick();
    check("R8 steps again after sync", ramp_o, 16'h0FF0);
  endtask

  // R9: halt mode
  task automatic t_susp_halt();
    susp_i = 1'b1;
    tick(); tick();
    check("R9 frozen", ramp_o, 16'h0FF0);
    pulse_sync();
    check("R9 sync ignored while frozen", ramp_o, 16'h0FF0);
    susp_i = 1'b0;
    tick();
    check("R9 resumes", ramp_o, 16'h0FE0);
  endtask

  // R10: finish current ramp then stop
  task automatic t_susp_finish();
    wr(3'd0, 16'h000D);
    pulse_sync();
    susp_i = 1'b1;
    tick(); tick();
    check("R10 keeps running", ramp_o, 16'h0FE0);
    pulse_sync();
    check("R10 no reload at stop sync", ramp_o, 16'h0FE0);
    tick(); tick();
    check("R10 stopped", ramp_o, 16'h0FE0);
    susp_i = 1'b0;
    tick();
    check("R10 continues after release", ramp_o, 16'h0FD0);
  endtask

  // R11: free run
  task automatic t_susp_free();
    wr(3'd0, 16'h0015);
    pulse_sync();
    susp_i = 1'b1;
    tick();
    check("R11 runs under suspend", ramp_o, 16'h0FF0);
    pulse_sync();
    check("R11 reloads under suspend", ramp_o, 16'h1000);
    susp_i = 1'b0;
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(); tick(); tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_shadow_now();
    t_shadow_sync();
    t_ramp_delay();
    t_saturate();
    t_active_peak();
    t_trip();
    t_susp_halt();
    t_susp_finish();
    t_susp_free();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule